// File: doc/BRIEF.md
# Multi-Lane Serial Audio Slave Receiver

This block takes in serial audio from an external master on up to four parallel data lanes. All lanes share one bit clock and one active-low frame sync. The bit clock, the frame sync and every data lane are brought into the system clock domain through synchronizer flops. Edge detection then picks out each rising edge of the bit clock, and at that edge one bit per lane is shifted in. No flop in the block is clocked by the bit clock itself.

A frame is two 32-bit words per lane. Once a full frame is in, the block places it in an output buffer and sends it out as a stream of words on a valid/ready port. First come the first words of all enabled lanes, from the lowest lane upward. Then come the second words in the same lane order. Each word carries its lane index and word index, and the final word of the frame is flagged. The downstream side may hold off at any time by keeping ready low; while it does, valid and the word on the port stay fixed. A frame that completes while the buffer still holds part of the previous frame is thrown away whole, and a one-cycle overrun pulse marks the loss.

A frame sync falling edge at any bit position other than the expected one sets a sticky error flag, discards the partial frame, and realigns the bit counter to the new sync. A clear input resets the flag.

Top module: `mlane_audio_rx`

## Requirements
- R1: After reset, `m_valid_o`, `fs_err_o` and `overrun_o` are all low.
- R2: On each lane, a frame is 64 bits sampled at rising bit-clock edges, most significant bit first. The first 32 bits form word 0 of that lane and the next 32 form word 1.
- R3: The frame sync is active low. Its falling edge is seen at the bit-clock edge just before bit 0 of a frame. The first falling edge after reset only aligns the counter: it raises no error, and the bits before it produce no output.
- R4: `lanes_m1_i` = k (0 to 3) enables lanes 0..k. A frame then yields 2(k+1) output words, and data on lanes above k never reaches the output.
- R5: Within a frame, words leave in this order: word 0 of lanes 0..k, then word 1 of lanes 0..k. `m_lane_o` gives the lane, `m_word_o` gives the word index (0 or 1), and `m_last_o` is high only on word 1 of lane k.
- R6: While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o`, `m_data_o`, `m_lane_o` and `m_word_o` hold. Once a frame's first word is shown, `m_valid_o` stays high until its last word is accepted.
- R7: If a frame completes while the output still holds any word of the previous frame, the new frame is discarded whole and `overrun_o` pulses high for one cycle.
- R8: A frame sync falling edge seen when the counter is not at bit 63 sets `fs_err_o`, which stays set. The partial frame is discarded, and the next bit is treated as bit 0 of a new frame.
- R9: `err_clr_i` clears `fs_err_o` on the next cycle, unless a new sync error is detected in that same cycle, in which case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock from the master |
| fsync_n_i | input | 1 | Active-low frame sync from the master |
| sd_i | input | LANES | Serial data, one bit per lane |
| lanes_m1_i | input | LANE_W | Number of enabled lanes minus one |
| err_clr_i | input | 1 | Clears the sticky sync error flag |
| m_valid_o | output | 1 | Output word valid |
| m_ready_i | input | 1 | Downstream ready |
| m_data_o | output | WORD_W | Sample word |
| m_lane_o | output | LANE_W | Lane index of the word |
| m_word_o | output | 1 | Word index within the lane (0 or 1) |
| m_last_o | output | 1 | Final word of the frame |
| fs_err_o | output | 1 | Sticky frame sync error |
| overrun_o | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
Every lane-count setting is tried with lane words whose top and bottom bits are both set and whose middle fields carry the frame, lane and word numbers. A reversed bit order, swapped words, a wrong lane order or leakage from disabled lanes therefore each give a distinct mismatch. The output side is driven with ready held high, ready toggled in an irregular pattern, and ready held low. These separate a correct stall hold from dropped or repeated words and from an overrun that keeps the wrong frame. A stream with a frame aborted by an early sync shows that the error is flagged, that the partial data never appears, and that the next full frame is captured intact after realignment.

// File: rtl/mlr_pkg.sv
package mlr_pkg;

  typedef enum logic {
    ALIGN_WAIT   = 1'b0,
    ALIGN_LOCKED = 1'b1
  } align_e;

  typedef enum logic {
    WSEL_FIRST  = 1'b0,
    WSEL_SECOND = 1'b1
  } word_sel_e;

endpackage

// File: rtl/mlr_sync.sv
module mlr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/mlr_bit_engine.sv
module mlr_bit_engine
  import mlr_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              fsn_s,
  input  logic [LANES-1:0]  sd_s,
  output logic              frm_done,
  output logic [WORD_W-1:0] frm_w0 [LANES],
  output logic [WORD_W-1:0] frm_w1 [LANES],
  output logic              fs_bad
);

  localparam int FRAME_BITS = 2 * WORD_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic             sck_q;
  logic             fsn_prev;
  logic             bit_stb;
  logic             fs_fall;
  logic             at_last;
  align_e           align_q;
  logic [CNT_W-1:0] bit_cnt;

  // one strobe per rising bit-clock edge, seen in the system clock domain
  assign bit_stb = sck_s & ~sck_q;
  assign fs_fall = bit_stb & fsn_prev & ~fsn_s;
  assign at_last = (bit_cnt == LAST_BIT);
  assign fs_bad  = fs_fall & (align_q == ALIGN_LOCKED) & ~at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      fsn_prev <= 1'b1;
      align_q  <= ALIGN_WAIT;
      bit_cnt  <= '0;
      frm_done <= 1'b0;
    end else begin
      sck_q    <= sck_s;
      frm_done <= bit_stb & (align_q == ALIGN_LOCKED) & at_last;
      if (bit_stb) begin
        fsn_prev <= fsn_s;
        if (fs_fall) begin
          // sync edge: next bit is bit 0 of a frame
          bit_cnt <= '0;
          align_q <= ALIGN_LOCKED;
        end else if (align_q == ALIGN_LOCKED) begin
          bit_cnt <= at_last ? '0 : bit_cnt + 1'b1;
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [FRAME_BITS-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       shreg <= '0;
      else if (bit_stb) shreg <= {shreg[FRAME_BITS-2:0], sd_s[l]};
    end

    assign frm_w0[l] = shreg[FRAME_BITS-1:WORD_W];
    assign frm_w1[l] = shreg[WORD_W-1:0];
  end

endmodule

// File: rtl/mlr_frame_out.sv
module mlr_frame_out
  import mlr_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WORD_W = 32,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_done,
  input  logic [WORD_W-1:0] frm_w0 [LANES],
  input  logic [WORD_W-1:0] frm_w1 [LANES],
  input  logic [LANE_W-1:0] lanes_m1,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [WORD_W-1:0] m_data,
  output logic [LANE_W-1:0] m_lane,
  output logic              m_word,
  output logic              m_last,
  output logic              overrun
);

  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

  logic              busy;
  logic [LANE_W-1:0] lane_q;
  logic [LANE_W-1:0] nl_q;
  word_sel_e         word_q;
  logic              fire;
  logic              lane_end;
  logic              take;
  logic [WORD_W-1:0] buf0 [LANES];
  logic [WORD_W-1:0] buf1 [LANES];

  assign fire     = busy & m_ready;
  assign lane_end = (lane_q == nl_q);
  assign take     = frm_done & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      lane_q  <= '0;
      nl_q    <= '0;
      word_q  <= WSEL_FIRST;
      overrun <= 1'b0;
    end else begin
      overrun <= frm_done & busy;
      if (take) begin
        busy   <= 1'b1;
        lane_q <= '0;
        word_q <= WSEL_FIRST;
        nl_q   <= (lanes_m1 > TOP_LANE) ? TOP_LANE : lanes_m1;
      end else if (fire) begin
        if (lane_end && word_q == WSEL_SECOND) begin
          busy <= 1'b0;
        end else if (lane_end) begin
          lane_q <= '0;
          word_q <= WSEL_SECOND;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf0[l] <= '0;
        buf1[l] <= '0;
      end else if (take) begin
        buf0[l] <= frm_w0[l];
        buf1[l] <= frm_w1[l];
      end
    end
  end

  assign m_valid = busy;
  assign m_lane  = lane_q;
  assign m_word  = (word_q == WSEL_SECOND);
  assign m_last  = busy & lane_end & (word_q == WSEL_SECOND);
  assign m_data  = (word_q == WSEL_SECOND) ? buf1[lane_q] : buf0[lane_q];

endmodule

// File: rtl/mlane_audio_rx.sv
module mlane_audio_rx #(
  parameter int LANES       = 4,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LANE_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              fsync_n_i,
  input  logic [LANES-1:0]  sd_i,
  input  logic [LANE_W-1:0] lanes_m1_i,
  input  logic              err_clr_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [WORD_W-1:0] m_data_o,
  output logic [LANE_W-1:0] m_lane_o,
  output logic              m_word_o,
  output logic              m_last_o,
  output logic              fs_err_o,
  output logic              overrun_o
);

  localparam int SYNC_W = LANES + 2;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] sync_out;
  logic              frm_done;
  logic              fs_bad;
  logic              fs_err_q;
  logic [WORD_W-1:0] frm_w0 [LANES];
  logic [WORD_W-1:0] frm_w1 [LANES];

  assign raw_in = {sd_i, fsync_n_i, sck_i};

  mlr_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  mlr_bit_engine #(
    .LANES  (LANES),
    .WORD_W (WORD_W)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (sync_out[0]),
    .fsn_s    (sync_out[1]),
    .sd_s     (sync_out[SYNC_W-1:2]),
    .frm_done (frm_done),
    .frm_w0   (frm_w0),
    .frm_w1   (frm_w1),
    .fs_bad   (fs_bad)
  );

  mlr_frame_out #(
    .LANES  (LANES),
    .WORD_W (WORD_W),
    .LANE_W (LANE_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_done (frm_done),
    .frm_w0   (frm_w0),
    .frm_w1   (frm_w1),
    .lanes_m1 (lanes_m1_i),
    .m_ready  (m_ready_i),
    .m_valid  (m_valid_o),
    .m_data   (m_data_o),
    .m_lane   (m_lane_o),
    .m_word   (m_word_o),
    .m_last   (m_last_o),
    .overrun  (overrun_o)
  );

  // sticky sync error; a new error wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fs_err_q <= 1'b0;
    else if (fs_bad)    fs_err_q <= 1'b1;
    else if (err_clr_i) fs_err_q <= 1'b0;
  end

  assign fs_err_o = fs_err_q;

endmodule

// File: rtl/mlr_checker.sv
module mlr_checker #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid_o,
  input logic              m_ready_i,
  input logic [WORD_W-1:0] m_data_o,
  input logic [LANE_W-1:0] m_lane_o,
  input logic              m_word_o,
  input logic              m_last_o,
  input logic              fs_err_o,
  input logic              err_clr_i,
  input logic              overrun_o,
  input logic              frm_done,
  input logic              fs_bad
);

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_lane_o) && $stable(m_word_o)); // R6

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o && m_ready_i && !m_last_o |=> m_valid_o); // R6

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid_o) |-> (m_lane_o == '0) && !m_word_o); // R5

  AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && m_valid_o |=> overrun_o); // R7

  AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> !overrun_o); // R7

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fs_bad |=> fs_err_o); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fs_err_o && !err_clr_i |=> fs_err_o); // R8

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_i && !fs_bad |=> !fs_err_o); // R9

endmodule

bind mlane_audio_rx mlr_checker #(
  .WORD_W (WORD_W),
  .LANE_W (LANE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .m_valid_o (m_valid_o),
  .m_ready_i (m_ready_i),
  .m_data_o  (m_data_o),
  .m_lane_o  (m_lane_o),
  .m_word_o  (m_word_o),
  .m_last_o  (m_last_o),
  .fs_err_o  (fs_err_o),
  .err_clr_i (err_clr_i),
  .overrun_o (overrun_o),
  .frm_done  (frm_done),
  .fs_bad    (fs_bad)
);

// File: tb/sim_mlane_audio_rx.sv
`timescale 1ns/1ps
module sim_mlane_audio_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        fsn = 1'b1;
  logic [3:0]  sd = '0;
  logic [1:0]  lanes_m1 = '0;
  logic        err_clr = 1'b0;
  logic        m_ready = 1'b0;
  logic        m_valid, m_word, m_last, fs_err, overrun;
  logic [31:0] m_data;
  logic [1:0]  m_lane;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int ready_mode = 0;
  int unsigned rcnt = 0;

  logic [31:0] cap_d [64];
  int          cap_l [64];
  int          cap_w [64];
  int          cap_last [64];
  int          cap_n = 0;
  int          ovr_n = 0;
  logic        stall_prev = 1'b0;
  logic [31:0] stall_d = '0;

  always #4 clk = ~clk;

  mlane_audio_rx u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_i      (sck),
    .fsync_n_i  (fsn),
    .sd_i       (sd),
    .lanes_m1_i (lanes_m1),
    .err_clr_i  (err_clr),
    .m_valid_o  (m_valid),
    .m_ready_i  (m_ready),
    .m_data_o   (m_data),
    .m_lane_o   (m_lane),
    .m_word_o   (m_word),
    .m_last_o   (m_last),
    .fs_err_o   (fs_err),
    .overrun_o  (overrun)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    rcnt = rcnt + 1;
    case (ready_mode)
      0:       m_ready = 1'b1;
      1:       m_ready = ((rcnt % 3) != 0);
      default: m_ready = 1'b0;
    endcase
  end

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (overrun) ovr_n++;
      if (stall_prev) chk("R6 stall hold", {31'd0, m_valid, m_data}, {31'd0, 1'b1, stall_d});
      if (m_valid && m_ready) begin
        if (cap_n < 64) begin
          cap_d[cap_n]    = m_data;
          cap_l[cap_n]    = int'(m_lane);
          cap_w[cap_n]    = int'(m_word);
          cap_last[cap_n] = int'(m_last);
        end
        cap_n++;
      end
      stall_prev = m_valid && !m_ready;
      stall_d    = m_data;
    end else begin
      stall_prev = 1'b0;
    end
  end

  task automatic wait_clk();
    @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic fs, input logic [3:0] d);
    sck = 1'b0; fsn = fs; sd = d;
    repeat (4) wait_clk();
    sck = 1'b1;
    repeat (4) wait_clk();
  endtask

  function automatic logic [31:0] mkw(input int f, input int l, input int w);
    return {4'h9, 4'(f), 8'(8'h11 * l), (w != 0) ? 8'hC3 : 8'h3C, 8'(8'h80 >> l) | 8'h01};
  endfunction

  // abort_at >= 32 ends the frame early with a sync edge at that bit
  task automatic send_frame(input int f, input int abort_at);
    for (int s = 0; s < 64; s++) begin
      logic       fs;
      logic [3:0] d;
      if (abort_at >= 0 && s == abort_at) begin
        send_bit(1'b0, 4'h0);
        return;
      end
      fs = (s <= 30 || s == 63) ? 1'b0 : 1'b1;
      for (int l = 0; l < 4; l++) begin
        logic [31:0] w;
        w = (s < 32) ? mkw(f, l, 0) : mkw(f, l, 1);
        d[l] = (s < 32) ? w[31 - s] : w[63 - s];
      end
      send_bit(fs, d);
    end
  endtask

  task automatic start_stream(input int lm1);
    lanes_m1 = 2'(lm1);
    rst_n = 1'b0; err_clr = 1'b0; sck = 1'b0; fsn = 1'b1; sd = '0;
    repeat (5) wait_clk();
    rst_n = 1'b1;
    repeat (3) wait_clk();
    cap_n = 0; ovr_n = 0;
    send_bit(1'b1, 4'hF);
    send_bit(1'b1, 4'hF);
    send_bit(1'b0, 4'hA);
  endtask

  task automatic verify_frame(input int base, input int f, input int n);
    for (int k = 0; k < 2 * n; k++) begin
      int l, w;
      l = k % n;
      w = k / n;
      chk("R2 word bits", {32'd0, cap_d[base + k]}, {32'd0, mkw(f, l, w)});
      chk("R5 lane tag", 64'(cap_l[base + k]), 64'(l));
      chk("R5 word tag", 64'(cap_w[base + k]), 64'(w));
      chk("R5 last flag", 64'(cap_last[base + k]), 64'(k == 2 * n - 1));
    end
  endtask

  task automatic t_reset();
    start_stream(3);
    chk("R1 valid after reset", 64'(m_valid), 64'd0);
    chk("R1 fs_err after reset", 64'(fs_err), 64'd0);
    chk("R1 overrun after reset", 64'(overrun), 64'd0);
  endtask

  task automatic t_order(input int n, input int rmode);
    start_stream(n - 1);
    ready_mode = rmode;
    send_frame(1, -1);
    send_frame(2, -1);
    repeat (40) wait_clk();
    chk("R4 word count", 64'(cap_n), 64'(4 * n));
    verify_frame(0, 1, n);
    verify_frame(2 * n, 2, n);
    chk("R3 no error on first align", 64'(fs_err), 64'd0);
    chk("R7 no overrun", 64'(ovr_n), 64'd0);
  endtask

  task automatic t_overrun();
    start_stream(1);
    ready_mode = 2;
    send_frame(3, -1);
    send_frame(4, -1);
    repeat (10) wait_clk();
    chk("R7 overrun pulses", 64'(ovr_n), 64'd1);
    chk("R6 nothing taken while stalled", 64'(cap_n), 64'd0);
    chk("R6 valid held", 64'(m_valid), 64'd1);
    ready_mode = 0;
    repeat (20) wait_clk();
    chk("R7 only first frame kept", 64'(cap_n), 64'd4);
    verify_frame(0, 3, 2);
    send_frame(5, -1);
    repeat (40) wait_clk();
    chk("R7 next frame accepted", 64'(cap_n), 64'd8);
    verify_frame(4, 5, 2);
    chk("R7 single overrun", 64'(ovr_n), 64'd1);
  endtask

  task automatic t_fserr();
    start_stream(3);
    ready_mode = 1;
    send_frame(6, -1);
    repeat (4) wait_clk();
    chk("R3 aligned without error", 64'(fs_err), 64'd0);
    send_frame(7, 40);
    repeat (10) wait_clk();
    chk("R8 error set", 64'(fs_err), 64'd1);
    send_frame(8, -1);
    repeat (40) wait_clk();
    chk("R8 partial dropped", 64'(cap_n), 64'd16);
    verify_frame(0, 6, 4);
    verify_frame(8, 8, 4);
    chk("R8 error sticky", 64'(fs_err), 64'd1);
    err_clr = 1'b1;
    wait_clk();
    err_clr = 1'b0;
    wait_clk();
    chk("R9 error cleared", 64'(fs_err), 64'd0);
    send_frame(9, -1);
    repeat (40) wait_clk();
    chk("R9 stays clear on good frame", 64'(fs_err), 64'd0);
    chk("R8 realigned stream continues", 64'(cap_n), 64'd24);
    verify_frame(16, 9, 4);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    t_reset();
    t_order(1, 0);
    t_order(2, 1);
    t_order(3, 0);
    t_order(4, 1);
    t_overrun();
    t_fserr();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule